// File: doc/BRIEF.md
# Byte-Wide Memory-Mapped Peripheral Bus Slave

This block sits between a small processor's load/store port and a handful of on-chip targets. Each access carries an 8-bit address, and the block decodes it onto one target. The targets are a 16-byte register-file RAM, a pair of UART registers plus a status word, and a general-purpose output latch and input port. A store drives write data with a write strobe. A load raises a read strobe and takes the byte from the read-data bus in the same cycle.

On the serial side the block does not shift bits itself. It hands a byte and a one-cycle load pulse to an external transmitter and watches that transmitter's busy flag. From an external receiver it takes a completed byte together with a one-cycle done pulse. It keeps that byte and a valid flag until software fetches it. Fetching the byte consumes it.

Top module: `mmio_fabric`

## Requirements
- R1: Addresses 0x00 to 0x0F are a read/write RAM. A load returns the byte most recently stored at that address.
- R2: A store to 0x40 while txBusy is 0 raises txLoad in that same cycle, with txData equal to the write data. While txBusy is 1 the store is ignored and txLoad stays 0. A load of 0x40 returns 0x00.
- R3: A load of 0x41 returns a status byte. Bit 0 is txBusy, bit 1 is the receive-valid flag, and bits 7..2 are 0.
- R4: A one-cycle rxDone pulse captures rxByte into the receive register and sets receive-valid from the next cycle on. A load of 0x42 returns the captured byte.
- R5: A load of 0x42 clears receive-valid at the following clock edge. If rxDone pulses in the same cycle, receive-valid stays set and the new byte replaces the old one.
- R6: A store to 0x80 updates gpioOut from the next cycle. A load of 0x80 returns the same value. No other access changes it.
- R7: A load of 0x81 returns the present gpioIn level. A store to 0x81 changes nothing.
- R8: Loads of any address outside the map return 0x00. Stores to such addresses, or to 0x41 or 0x42, change no RAM byte and do not change gpioOut.
- R9: While rstN is low at a clock edge, every RAM byte, gpioOut, the receive register and receive-valid become 0.
- R10: busRdata is 0x00 in any cycle in which busRe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 8 | Access address |
| busWdata | input | 8 | Store data |
| busWe | input | 1 | Store strobe |
| busRe | input | 1 | Load strobe |
| busRdata | output | 8 | Load data, valid in the cycle of busRe |
| txLoad | output | 1 | One-cycle pulse that starts the transmitter |
| txData | output | 8 | Byte handed to the transmitter |
| txBusy | input | 1 | Transmitter busy flag |
| rxDone | input | 1 | One-cycle pulse: receiver has a byte |
| rxByte | input | 8 | Byte from the receiver |
| gpioOut | output | 8 | Output pin levels |
| gpioIn | input | 8 | Input pin levels |

## Verification
A wrong decode or a corrupted RAM byte shows on busRdata at the first load of the affected address. The bench therefore sweeps every one of the 256 addresses against a model and re-reads the RAM and output latch after stray stores. A receive-valid flag in the wrong state appears in the status byte on the very next load. A popped byte that the clear wrongly discarded also shows there, so the bench loads the status immediately after each pop and after a pop that collides with a new byte. A mis-gated transmit pulse is visible on txLoad in the same cycle as the store.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int RAM_DEPTH = 16;

  localparam logic [AW-1:0] ADDR_TX   = 8'h40;
  localparam logic [AW-1:0] ADDR_STAT = 8'h41;
  localparam logic [AW-1:0] ADDR_RX   = 8'h42;
  localparam logic [AW-1:0] ADDR_GOUT = 8'h80;
  localparam logic [AW-1:0] ADDR_GIN  = 8'h81;

  typedef struct packed {
    logic ramWe;
    logic gpioWe;
    logic txGo;
    logic rxPop;
    logic selRam;
    logic selStat;
    logic selRx;
    logic selGout;
    logic selGin;
  } strobe_t;
endpackage

// File: rtl/mmio_ctrl.sv
module mmio_ctrl
  import mmio_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DEPTH  = RAM_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              txBusy,
  output strobe_t           strb
);
  logic inRam, hitTx, hitStat, hitRx, hitGout, hitGin;

  always_comb begin
    inRam   = (busAddr < ADDR_W'(DEPTH));
    hitTx   = (busAddr == ADDR_TX);
    hitStat = (busAddr == ADDR_STAT);
    hitRx   = (busAddr == ADDR_RX);
    hitGout = (busAddr == ADDR_GOUT);
    hitGin  = (busAddr == ADDR_GIN);

    strb.ramWe   = busWe & inRam;
    strb.gpioWe  = busWe & hitGout;
    strb.txGo    = busWe & hitTx & ~txBusy;
    strb.rxPop   = busRe & hitRx;
    strb.selRam  = busRe & inRam;
    strb.selStat = busRe & hitStat;
    strb.selRx   = busRe & hitRx;
    strb.selGout = busRe & hitGout;
    strb.selGin  = busRe & hitGin;
  end

  // R8: at most one read target is ever selected
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selRam, strb.selStat, strb.selRx, strb.selGout, strb.selGin}));
endmodule

// File: rtl/mmio_dpath.sv
module mmio_dpath
  import mmio_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW,
  parameter int DEPTH  = RAM_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              txBusy,
  input  logic              rxDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] gpioIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] gpioOut
);
  localparam int RAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [RAW-1:0]    ramIdx;
  logic [DATA_W-1:0] gpioReg;
  logic [DATA_W-1:0] rxData;
  logic              rxValid;

  assign ramIdx  = busAddr[RAW-1:0];
  assign gpioOut = gpioReg;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) ram[i] <= '0;
      else if (strb.ramWe && ramIdx == RAW'(i)) ram[i] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) gpioReg <= '0;
    else if (strb.gpioWe) gpioReg <= busWdata;
  end

  // a new byte outranks the pop so it is never dropped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      if (strb.rxPop) rxValid <= 1'b0;
      if (rxDone) begin
        rxValid <= 1'b1;
        rxData  <= rxByte;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.selRam)  busRdata = ram[ramIdx];
    if (strb.selStat) busRdata = DATA_W'({rxValid, txBusy});
    if (strb.selRx)   busRdata = rxData;
    if (strb.selGout) busRdata = gpioReg;
    if (strb.selGin)  busRdata = gpioIn;
  end

  assert_rx_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> (rxValid && rxData == $past(rxByte)));

  assert_pop_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxPop && !rxDone) |=> !rxValid);

  assert_gpio_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.gpioWe |=> $stable(gpioReg));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rstN |=> (gpioReg == '0 && !rxValid && rxData == '0));
endmodule

// File: rtl/mmio_fabric.sv
module mmio_fabric
  import mmio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic          busWe,
  input  logic          busRe,
  output logic [DW-1:0] busRdata,
  output logic          txLoad,
  output logic [DW-1:0] txData,
  input  logic          txBusy,
  input  logic          rxDone,
  input  logic [DW-1:0] rxByte,
  output logic [DW-1:0] gpioOut,
  input  logic [DW-1:0] gpioIn
);
  strobe_t strb;

  mmio_ctrl #(.ADDR_W(AW), .DEPTH(RAM_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .txBusy(txBusy), .strb(strb)
  );

  mmio_dpath #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(RAM_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .txBusy(txBusy), .rxDone(rxDone),
    .rxByte(rxByte), .gpioIn(gpioIn), .busRdata(busRdata),
    .gpioOut(gpioOut)
  );

  assign txLoad = strb.txGo;
  assign txData = busWdata;

  assert_tx_blocked_R2: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !txLoad);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> busRdata == '0);
endmodule

// File: tb/mmio_fabric_bench.sv
module mmio_fabric_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, rxByte = '0, gpioIn = '0;
  logic       busWe = 1'b0, busRe = 1'b0, txBusy = 1'b0, rxDone = 1'b0;
  logic [7:0] busRdata, txData, gpioOut;
  logic       txLoad;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] mRam [16];
  logic [7:0] mGpio;
  logic [7:0] mRxD;
  logic       mRxV;

  always #4 clk = ~clk;

  mmio_fabric u_mmio_fabric (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .txLoad(txLoad),
    .txData(txData), .txBusy(txBusy), .rxDone(rxDone), .rxByte(rxByte),
    .gpioOut(gpioOut), .gpioIn(gpioIn)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] a);
    if (a < 8'd16) return mRam[a[3:0]];
    case (a)
      8'h41:   return {6'b0, mRxV, txBusy};
      8'h42:   return mRxD;
      8'h80:   return mGpio;
      8'h81:   return gpioIn;
      default: return 8'h00;
    endcase
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // load with the model's value checked mid-cycle, model side effects applied
  task automatic busRead(input string tag, input logic [7:0] a);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #2 check(tag, busRdata, model(a));
    if (a == 8'h42) mRxV = 1'b0;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic rxPulse(input logic [7:0] b);
    @(negedge clk);
    rxByte = b; rxDone = 1'b1;
    @(negedge clk);
    rxDone = 1'b0;
    mRxD = b; mRxV = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) mRam[i] = 8'h00;
    mGpio = 8'h00; mRxD = 8'h00; mRxV = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    doReset();

    // R9: reset state
    #2 check("R9 gpioOut after reset", gpioOut, 8'h00);
    for (int a = 0; a < 16; a++) busRead("R9 RAM after reset", 8'(a));
    busRead("R9 status after reset", 8'h41);

    // R1: fill the RAM with an arithmetic pattern, read back
    for (int a = 0; a < 16; a++) begin
      busWrite(8'(a), 8'(a * 37 + 5));
      mRam[a] = 8'(a * 37 + 5);
    end
    for (int a = 0; a < 16; a++) busRead("R1 RAM readback", 8'(a));

    // R6: output latch
    @(negedge clk);
    busAddr = 8'h80; busWdata = 8'hA5; busWe = 1'b1;
    #2 check("R6 gpioOut before edge", gpioOut, 8'h00);
    @(negedge clk);
    busWe = 1'b0; mGpio = 8'hA5;
    check("R6 gpioOut after edge", gpioOut, 8'hA5);
    busRead("R6 gpio readback", 8'h80);

    // R7: input port, store ignored
    gpioIn = 8'h3C;
    busRead("R7 gpio input", 8'h81);
    busWrite(8'h81, 8'hFF);
    #2 check("R7 store to input leaves gpioOut", gpioOut, 8'hA5);
    gpioIn = 8'hC3;
    busRead("R7 gpio input after store", 8'h81);

    // R2: transmit load
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      txBusy = 1'(b); busAddr = 8'h40; busWdata = 8'h69; busWe = 1'b1;
      #2 check("R2 txLoad", {7'b0, txLoad}, (b == 0) ? 8'h01 : 8'h00);
      if (b == 0) check("R2 txData", txData, 8'h69);
      @(negedge clk);
      busWe = 1'b0;
      #2 check("R2 txLoad idle", {7'b0, txLoad}, 8'h00);
    end
    busRead("R3 status with tx busy", 8'h41);
    txBusy = 1'b0;
    busRead("R2 read of tx address", 8'h40);

    // R4/R5: receive and pop
    rxPulse(8'h5A);
    busRead("R3 R4 status valid", 8'h41);
    busRead("R4 rx byte", 8'h42);
    busRead("R5 status after pop", 8'h41);

    // R5: pop colliding with a new byte
    rxPulse(8'h11);
    @(negedge clk);
    busAddr = 8'h42; busRe = 1'b1; rxByte = 8'h77; rxDone = 1'b1;
    #2 check("R5 pop returns old byte", busRdata, 8'h11);
    @(negedge clk);
    busRe = 1'b0; rxDone = 1'b0; mRxD = 8'h77; mRxV = 1'b1;
    busRead("R5 valid kept on collision", 8'h41);
    busRead("R5 new byte kept", 8'h42);
    busRead("R5 status after second pop", 8'h41);

    // R8/R3: full address sweep against the model
    rxPulse(8'hE1);
    gpioIn = 8'h96;
    for (int a = 0; a < 256; a++) busRead("R8 sweep", 8'(a));

    // R8: stores to unmapped and read-only addresses
    for (int a = 16; a < 256; a++)
      if (a != 8'h40 && a != 8'h80) busWrite(8'(a), 8'hFF);
    #2 check("R8 gpioOut after stray stores", gpioOut, mGpio);
    for (int a = 0; a < 16; a++) busRead("R8 RAM after stray stores", 8'(a));

    // R10: idle read bus
    @(negedge clk);
    busAddr = 8'h80; busRe = 1'b0;
    #2 check("R10 idle rdata gpio", busRdata, 8'h00);
    busAddr = 8'h03;
    #1 check("R10 idle rdata ram", busRdata, 8'h00);

    // R9: reset in mid-run
    rxPulse(8'h42);
    doReset();
    #2 check("R9 gpioOut after second reset", gpioOut, 8'h00);
    for (int a = 0; a < 16; a++) busRead("R9 RAM after second reset", 8'(a));
    busRead("R9 status after second reset", 8'h41);
    busRead("R9 rx byte after second reset", 8'h42);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule